// File: doc/BRIEF.md
# Task-File Sector Transfer Channel

This block is one channel of a task-file style disk interface. Software programs a small set of byte registers (sector count, starting sector, cylinder low and high, drive/head, feature, device control) and then writes a command code. A read or write command moves whole sectors, one at a time, through an internal byte buffer that the host empties or fills over a single data address. A separate request/acknowledge port lets a sector store fetch a sector into the buffer or take a filled sector out of it.

A five-state machine runs each transfer: `ST_IDLE`, `ST_LOAD` (host fills the buffer), `ST_DRAIN` (host empties the buffer), `ST_BUSY_LOAD` (after a full buffer) and `ST_BUSY_DRAIN` (after an empty buffer). Its transitions are: idle to busy-drain on a read command (priming fetch); idle to load on a write command; load to busy-load on the last byte written; drain to busy-drain on the last byte read; busy-load to load, or busy-drain to drain, when the ready delay expires with sectors left; either busy state to idle when it expires with none left; anything unexpected stays put. Each expiry of the ready delay asks for an interrupt, which software can mask and clear.

Top module: `ata_xfer_chan`

## Requirements
- R1: After reset the status byte reads 0x40, `irq` is 0, `proto_err` is 0 and `st_req` is 0.
- R2: A read at address 7 or 8 returns the status byte: 0x40 in idle, 0x08 in load or drain, 0x80 in either busy state.
- R3: In idle, writing 0x20 or 0x21 to address 7 starts a multi-sector read and 0x30 or 0x31 starts a multi-sector write; any other code leaves the block idle with no other effect.
- R4: A sector count of 0 (address 2) transfers 256 sectors; any other value transfers that many.
- R5: A read command goes straight to busy and requests the first sector from the store (`st_write`=0) before any data may be drained.
- R6: When the buffer has been fully written (write) or fully read with sectors left (read), the block enters busy and holds `st_req` high until `st_ack`; `st_write` is 1 for a store write and 0 for a fetch.
- R7: A busy state lasts exactly READY_DELAY cycles after the acknowledge edge (or after entry, when no fetch is due), then moves to load or drain if sectors remain, else to idle.
- R8: Each ready-delay expiry sets `irq` if bit 1 of the control register (address 8, write) is 0; writing address 8 with bit 1 set clears `irq`.
- R9: Reading address 7 clears `irq`; reading address 8 leaves it unchanged.
- R10: The store block number `st_lba` starts at {drive/head[3:0], cylinder high, cylinder low, sector number} and rises by one after each acknowledged sector; `st_drive` is drive/head bit 4 captured at the command.
- R11: A data-port (address 0) access outside the matching load or drain state, or a command write outside idle, sets `proto_err`, which stays set until reset; the access has no other effect.
- R12: Addresses 1 to 6 (feature, count, sector number, cylinder low, cylinder high, drive/head) read back the last value written.
- R13: Host data byte k of a sector maps to buffer index k on the store buffer port, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe |
| hst_addr | input | 4 | Host register address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data (combinational) |
| irq | output | 1 | Interrupt request |
| proto_err | output | 1 | Sticky protocol-error flag |
| st_req | output | 1 | Sector store request |
| st_write | output | 1 | 1: store takes buffer; 0: store fills buffer |
| st_drive | output | 1 | Selected drive |
| st_lba | output | 28 | Sector block number |
| st_ack | input | 1 | Store completion, one cycle |
| st_buf_idx | input | log2(SECTOR_BYTES) | Store buffer byte index |
| st_buf_we | input | 1 | Store buffer write enable |
| st_buf_wdata | input | 8 | Store buffer write byte |
| st_buf_rdata | output | 8 | Store buffer read byte |

## Verification
The assertions assume that the store raises `st_ack` only while `st_req` is high and for one cycle, and that the host never asserts both strobes in the same cycle. The bench's store responder waits for a request, walks the buffer one index per cycle, and pulses the acknowledge once; host tasks issue one strobe at a time with an idle cycle between. A behavioural model of the channel is advanced on every edge from the same inputs and compared against interrupt, error and store-port outputs each cycle.

// File: rtl/ata_xfer_pkg.sv
`timescale 1ns/1ps
package ata_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DRAIN,
        ST_BUSY_LOAD,
        ST_BUSY_DRAIN
    } xfer_state_e;

    // host register addresses
    localparam logic [3:0] A_DATA    = 4'd0;
    localparam logic [3:0] A_FEAT    = 4'd1;
    localparam logic [3:0] A_COUNT   = 4'd2;
    localparam logic [3:0] A_SECNUM  = 4'd3;
    localparam logic [3:0] A_CYLLO   = 4'd4;
    localparam logic [3:0] A_CYLHI   = 4'd5;
    localparam logic [3:0] A_DEVHEAD = 4'd6;
    localparam logic [3:0] A_CMDSTAT = 4'd7;
    localparam logic [3:0] A_CTRLALT = 4'd8;

    localparam logic [7:0] STAT_READY = 8'h40;
    localparam logic [7:0] STAT_DRQ   = 8'h08;
    localparam logic [7:0] STAT_BUSY  = 8'h80;

    // upper seven bits of the accepted command codes
    localparam logic [6:0] CMD_RD_PFX = 7'h10;
    localparam logic [6:0] CMD_WR_PFX = 7'h18;

    localparam int MASK_BIT  = 1;
    localparam int DSEL_BIT  = 4;
    localparam int LBA_W     = 28;

endpackage

// File: rtl/ata_taskfile_regs.sv
`timescale 1ns/1ps
module ata_taskfile_regs
    import ata_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] feature_q,
    output logic [7:0] count_q,
    output logic [7:0] secnum_q,
    output logic [7:0] cyllo_q,
    output logic [7:0] cylhi_q,
    output logic [7:0] devhead_q,
    output logic       intr_mask_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            feature_q   <= '0;
            count_q     <= '0;
            secnum_q    <= '0;
            cyllo_q     <= '0;
            cylhi_q     <= '0;
            devhead_q   <= '0;
            intr_mask_q <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_FEAT:    feature_q   <= wdata;
                A_COUNT:   count_q     <= wdata;
                A_SECNUM:  secnum_q    <= wdata;
                A_CYLLO:   cyllo_q     <= wdata;
                A_CYLHI:   cylhi_q     <= wdata;
                A_DEVHEAD: devhead_q   <= wdata;
                A_CTRLALT: intr_mask_q <= wdata[MASK_BIT];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ata_sector_buf.sv
`timescale 1ns/1ps
module ata_sector_buf #(
    parameter int DEPTH = 512,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/ata_ready_timer.sv
`timescale 1ns/1ps
module ata_ready_timer #(
    parameter int DELAY = 16,
    localparam int CW   = (DELAY > 1) ? $clog2(DELAY) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= CW'(DELAY - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run_q && (cnt_q == '0);

endmodule

// File: rtl/ata_xfer_chan.sv
`timescale 1ns/1ps
module ata_xfer_chan
    import ata_xfer_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int READY_DELAY  = 16,
    localparam int POS_W = (SECTOR_BYTES > 1) ? $clog2(SECTOR_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_wr,
    input  logic             hst_rd,
    input  logic [3:0]       hst_addr,
    input  logic [7:0]       hst_wdata,
    output logic [7:0]       hst_rdata,
    output logic             irq,
    output logic             proto_err,
    output logic             st_req,
    output logic             st_write,
    output logic             st_drive,
    output logic [LBA_W-1:0] st_lba,
    input  logic             st_ack,
    input  logic [POS_W-1:0] st_buf_idx,
    input  logic             st_buf_we,
    input  logic [7:0]       st_buf_wdata,
    output logic [7:0]       st_buf_rdata
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(SECTOR_BYTES - 1);
    localparam int               REM_W    = 9;

    // host access decode
    logic data_wr, data_rd, cmd_wr, stat_rd, ctrl_wr;
    logic is_rd_cmd, is_wr_cmd, data_acc;

    assign data_wr   = hst_wr && (hst_addr == A_DATA);
    assign data_rd   = hst_rd && (hst_addr == A_DATA);
    assign cmd_wr    = hst_wr && (hst_addr == A_CMDSTAT);
    assign stat_rd   = hst_rd && (hst_addr == A_CMDSTAT);
    assign ctrl_wr   = hst_wr && (hst_addr == A_CTRLALT);
    assign data_acc  = data_wr || data_rd;
    assign is_rd_cmd = (hst_wdata[7:1] == CMD_RD_PFX);
    assign is_wr_cmd = (hst_wdata[7:1] == CMD_WR_PFX);

    // task file
    logic [7:0] feature_q, count_q, secnum_q, cyllo_q, cylhi_q, devhead_q;
    logic       intr_mask_q;

    ata_taskfile_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (hst_wr),
        .addr        (hst_addr),
        .wdata       (hst_wdata),
        .feature_q   (feature_q),
        .count_q     (count_q),
        .secnum_q    (secnum_q),
        .cyllo_q     (cyllo_q),
        .cylhi_q     (cylhi_q),
        .devhead_q   (devhead_q),
        .intr_mask_q (intr_mask_q)
    );

    logic [REM_W-1:0] sect_total;
    logic [LBA_W-1:0] start_lba;

    assign sect_total = (count_q == 8'd0) ? REM_W'(256) : REM_W'(count_q);
    assign start_lba  = {devhead_q[3:0], cylhi_q, cyllo_q, secnum_q};

    // sequencing state
    xfer_state_e      state_q, state_d;
    logic [REM_W-1:0] rem_q, rem_d;
    logic [LBA_W-1:0] lba_q, lba_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic             pend_q, pend_d;
    logic             drive_q, drive_d;
    logic             timer_start, timer_exp, done_evt, perr_set;

    ata_ready_timer #(.DELAY(READY_DELAY)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (timer_start),
        .expired (timer_exp)
    );

    always_comb begin
        state_d     = state_q;
        rem_d       = rem_q;
        lba_d       = lba_q;
        pos_d       = pos_q;
        pend_d      = pend_q;
        drive_d     = drive_q;
        timer_start = 1'b0;
        done_evt    = 1'b0;
        perr_set    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (data_acc) perr_set = 1'b1;
                if (cmd_wr && (is_rd_cmd || is_wr_cmd)) begin
                    rem_d   = sect_total;
                    lba_d   = start_lba;
                    drive_d = devhead_q[DSEL_BIT];
                    pos_d   = '0;
                    if (is_rd_cmd) begin
                        pend_d  = 1'b1;          // priming fetch
                        state_d = ST_BUSY_DRAIN;
                    end else begin
                        state_d = ST_LOAD;
                    end
                end
            end
            ST_LOAD: begin
                if (cmd_wr || data_rd) perr_set = 1'b1;
                if (data_wr) begin
                    if (pos_q == LAST_POS) begin
                        pos_d   = '0;
                        rem_d   = rem_q - 1'b1;
                        pend_d  = 1'b1;
                        state_d = ST_BUSY_LOAD;
                    end else begin
                        pos_d = pos_q + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (cmd_wr || data_wr) perr_set = 1'b1;
                if (data_rd) begin
                    if (pos_q == LAST_POS) begin
                        pos_d   = '0;
                        rem_d   = rem_q - 1'b1;
                        state_d = ST_BUSY_DRAIN;
                        if (rem_q == REM_W'(1)) timer_start = 1'b1;
                        else                    pend_d      = 1'b1;
                    end else begin
                        pos_d = pos_q + 1'b1;
                    end
                end
            end
            ST_BUSY_LOAD, ST_BUSY_DRAIN: begin
                if (cmd_wr || data_acc) perr_set = 1'b1;
                if (pend_q) begin
                    if (st_ack) begin
                        pend_d      = 1'b0;
                        lba_d       = lba_q + LBA_W'(1);
                        timer_start = 1'b1;
                    end
                end else if (timer_exp) begin
                    done_evt = 1'b1;
                    if (rem_q == '0)                state_d = ST_IDLE;
                    else if (state_q == ST_BUSY_LOAD) state_d = ST_LOAD;
                    else                            state_d = ST_DRAIN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            lba_q   <= '0;
            pos_q   <= '0;
            pend_q  <= 1'b0;
            drive_q <= 1'b0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            lba_q   <= lba_d;
            pos_q   <= pos_d;
            pend_q  <= pend_d;
            drive_q <= drive_d;
        end
    end

    // registered outputs
    logic irq_q, perr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            if (done_evt && !intr_mask_q)                  irq_q <= 1'b1;
            else if (stat_rd || (ctrl_wr && hst_wdata[MASK_BIT])) irq_q <= 1'b0;
            if (perr_set) perr_q <= 1'b1;
        end
    end

    // sector buffer: host writes while loading, store writes while fetching
    logic             host_we, store_we, buf_we;
    logic [POS_W-1:0] buf_waddr;
    logic [7:0]       buf_wdata, host_byte;

    assign host_we   = (state_q == ST_LOAD) && data_wr;
    assign store_we  = (state_q == ST_BUSY_DRAIN) && pend_q && st_buf_we;
    assign buf_we    = host_we || store_we;
    assign buf_waddr = host_we ? pos_q : st_buf_idx;
    assign buf_wdata = host_we ? hst_wdata : st_buf_wdata;

    ata_sector_buf #(.DEPTH(SECTOR_BYTES)) u_buf (
        .clk     (clk),
        .we      (buf_we),
        .waddr   (buf_waddr),
        .wdata   (buf_wdata),
        .raddr_a (pos_q),
        .rdata_a (host_byte),
        .raddr_b (st_buf_idx),
        .rdata_b (st_buf_rdata)
    );

    // combinational outputs
    logic [7:0] status_byte;

    always_comb begin
        unique case (state_q)
            ST_LOAD, ST_DRAIN:           status_byte = STAT_DRQ;
            ST_BUSY_LOAD, ST_BUSY_DRAIN: status_byte = STAT_BUSY;
            default:                     status_byte = STAT_READY;
        endcase
        case (hst_addr)
            A_DATA:    hst_rdata = (state_q == ST_DRAIN) ? host_byte : 8'h00;
            A_FEAT:    hst_rdata = feature_q;
            A_COUNT:   hst_rdata = count_q;
            A_SECNUM:  hst_rdata = secnum_q;
            A_CYLLO:   hst_rdata = cyllo_q;
            A_CYLHI:   hst_rdata = cylhi_q;
            A_DEVHEAD: hst_rdata = devhead_q;
            A_CMDSTAT, A_CTRLALT: hst_rdata = status_byte;
            default:   hst_rdata = 8'h00;
        endcase
    end

    assign irq       = irq_q;
    assign proto_err = perr_q;
    assign st_req    = pend_q && ((state_q == ST_BUSY_LOAD) || (state_q == ST_BUSY_DRAIN));
    assign st_write  = (state_q == ST_BUSY_LOAD);
    assign st_drive  = drive_q;
    assign st_lba    = lba_q;

endmodule

// File: rtl/ata_xfer_chk.sv
`timescale 1ns/1ps
module ata_xfer_chk
    import ata_xfer_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input xfer_state_e state_q,
    input logic        st_req,
    input logic        st_ack,
    input logic        irq,
    input logic        proto_err,
    input logic        intr_mask,
    input logic        hst_rd,
    input logic        hst_wr,
    input logic [3:0]  hst_addr,
    input logic [7:0]  hst_wdata
);

    // R11
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R5
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> (state_q == ST_BUSY_LOAD || state_q == ST_BUSY_DRAIN));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !st_ack) |=> st_req);

    // R8
    irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !$past(intr_mask));

    // R7
    irq_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(state_q) == ST_BUSY_LOAD || $past(state_q) == ST_BUSY_DRAIN));

    // R9
    alt_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && hst_rd && !hst_wr && hst_addr == A_CTRLALT) |=> irq);

    // R3
    bad_cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && hst_wr && hst_addr == A_CMDSTAT &&
         hst_wdata != 8'h20 && hst_wdata != 8'h21 &&
         hst_wdata != 8'h30 && hst_wdata != 8'h31) |=> (state_q == ST_IDLE));

endmodule

bind ata_xfer_chan ata_xfer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .st_req    (st_req),
    .st_ack    (st_ack),
    .irq       (irq),
    .proto_err (proto_err),
    .intr_mask (intr_mask_q),
    .hst_rd    (hst_rd),
    .hst_wr    (hst_wr),
    .hst_addr  (hst_addr),
    .hst_wdata (hst_wdata)
);

// File: tb/sim_ata_xfer_chan.sv
`timescale 1ns/1ps
module sim_ata_xfer_chan;

    localparam int SB  = 8;
    localparam int DLY = 3;
    localparam int PW  = $clog2(SB);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr = 1'b0, hst_rd = 1'b0;
    logic [3:0]  hst_addr = '0;
    logic [7:0]  hst_wdata = '0;
    logic [7:0]  hst_rdata;
    logic        irq, proto_err, st_req, st_write, st_drive;
    logic [27:0] st_lba;
    logic        st_ack = 1'b0;
    logic [PW-1:0] st_buf_idx = '0;
    logic        st_buf_we = 1'b0;
    logic [7:0]  st_buf_wdata = '0;
    logic [7:0]  st_buf_rdata;

    ata_xfer_chan #(.SECTOR_BYTES(SB), .READY_DELAY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .irq(irq), .proto_err(proto_err), .st_req(st_req), .st_write(st_write),
        .st_drive(st_drive), .st_lba(st_lba), .st_ack(st_ack),
        .st_buf_idx(st_buf_idx), .st_buf_we(st_buf_we),
        .st_buf_wdata(st_buf_wdata), .st_buf_rdata(st_buf_rdata)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic logic [7:0] pat(input int l, input int i);
        return 8'(l * 7 + i * 13 + 5);
    endfunction

    // ---------------- behavioural reference model ----------------
    // states: 0 idle, 1 load, 2 drain, 3 busy after load, 4 busy after drain
    int         m_state, m_rem, m_lba, m_pos, m_wait;
    bit         m_pend, m_irq, m_perr, m_drive;
    logic [7:0] m_tf [0:15];

    function automatic int stat_of(input int s);
        if (s == 0) return 'h40;
        if (s <= 2) return 'h08;
        return 'h80;
    endfunction

    task automatic model_reset();
        m_state = 0; m_rem = 0; m_lba = 0; m_pos = 0; m_wait = 0;
        m_pend = 0; m_irq = 0; m_perr = 0; m_drive = 0;
        for (int k = 0; k < 16; k++) m_tf[k] = 8'h00;
    endtask

    task automatic model_start();
        m_rem   = (m_tf[2] == 0) ? 256 : int'(m_tf[2]);
        m_lba   = {m_tf[6][3:0], m_tf[5], m_tf[4], m_tf[3]};
        m_drive = m_tf[6][4];
        m_pos   = 0;
    endtask

    task automatic model_step();
        bit dwr, drd, cmd, srd, cwr, evt;
        int s;
        dwr = hst_wr && hst_addr == 0;
        drd = hst_rd && hst_addr == 0;
        cmd = hst_wr && hst_addr == 7;
        srd = hst_rd && hst_addr == 7;
        cwr = hst_wr && hst_addr == 8;
        evt = 0;
        s   = m_state;
        case (s)
            0: begin
                if (dwr || drd) m_perr = 1;
                if (cmd && (hst_wdata == 8'h20 || hst_wdata == 8'h21)) begin
                    model_start(); m_pend = 1; m_state = 4;
                end else if (cmd && (hst_wdata == 8'h30 || hst_wdata == 8'h31)) begin
                    model_start(); m_state = 1;
                end
            end
            1: begin
                if (cmd || drd) m_perr = 1;
                if (dwr) begin
                    m_pos++;
                    if (m_pos == SB) begin m_pos = 0; m_rem--; m_pend = 1; m_state = 3; end
                end
            end
            2: begin
                if (cmd || dwr) m_perr = 1;
                if (drd) begin
                    m_pos++;
                    if (m_pos == SB) begin
                        m_pos = 0; m_rem--; m_state = 4;
                        if (m_rem > 0) m_pend = 1; else m_wait = DLY;
                    end
                end
            end
            default: begin
                if (cmd || dwr || drd) m_perr = 1;
                if (m_pend) begin
                    if (st_ack) begin m_pend = 0; m_lba = (m_lba + 1) & 32'h0FFF_FFFF; m_wait = DLY; end
                end else begin
                    m_wait--;
                    if (m_wait == 0) begin
                        evt = 1;
                        m_state = (m_rem == 0) ? 0 : ((s == 3) ? 1 : 2);
                    end
                end
            end
        endcase
        if (evt && !m_tf[8][1]) m_irq = 1;
        else if (srd || (cwr && hst_wdata[1])) m_irq = 0;
        if (hst_wr && ((hst_addr >= 1 && hst_addr <= 6) || hst_addr == 8))
            m_tf[hst_addr] = hst_wdata;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else        model_step();
        #1;
        if (rst_n) begin
            check(irq == m_irq, "R7/R8 irq timing", irq, m_irq);
            check(proto_err == m_perr, "R11 proto_err", proto_err, m_perr);
            check(st_req == (m_state >= 3 && m_pend), "R6 st_req", st_req, (m_state >= 3 && m_pend));
            if (st_req) check(st_write == (m_state == 3), "R6 st_write", st_write, (m_state == 3));
            check(st_lba == 28'(m_lba), "R10 st_lba", st_lba, m_lba);
            check(st_drive == m_drive, "R10 st_drive", st_drive, m_drive);
        end
    end

    // ---------------- sector store responder ----------------
    int wlog_byte[$];
    int req_lba[$];
    int req_drv[$];
    int n_store_wr = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && st_req) begin
                req_lba.push_back(int'(st_lba));
                req_drv.push_back(int'(st_drive));
                if (st_write) n_store_wr++;
                for (int i = 0; i < SB; i++) begin
                    st_buf_idx   = PW'(i);
                    st_buf_we    = !st_write;
                    st_buf_wdata = pat(int'(st_lba), i);
                    #1;
                    if (st_write) wlog_byte.push_back(int'(st_buf_rdata));
                    @(negedge clk);
                end
                st_buf_we = 1'b0;
                st_ack    = 1'b1;
                @(negedge clk);
                st_ack    = 1'b0;
            end
        end
    end

    // ---------------- host tasks ----------------
    task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic hread(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        hst_addr = a; hst_rd = 1'b1;
        #1;
        v = hst_rdata;
        if (a == 7 || a == 8) check(v == stat_of(m_state), "R2 status byte", v, stat_of(m_state));
        if (a == 0 && m_state == 2)
            check(v == pat(m_lba - 1, m_pos), "R13 drained byte", v, pat(m_lba - 1, m_pos));
        @(negedge clk);
        hst_rd = 1'b0;
    endtask

    task automatic wait_status(input logic [7:0] want, input string tag);
        logic [7:0] v;
        v = 8'h00;
        for (int k = 0; k < 300; k++) begin
            hread(8, v);
            if (v == want) break;
        end
        check(v == want, tag, v, want);
    endtask

    task automatic setup(input logic [7:0] cnt, input logic [7:0] dh,
                         input logic [7:0] ch, input logic [7:0] cl, input logic [7:0] sn);
        hwrite(2, cnt); hwrite(3, sn); hwrite(4, cl); hwrite(5, ch); hwrite(6, dh);
    endtask

    task automatic drain_sectors(input int n);
        logic [7:0] v;
        for (int s = 0; s < n; s++) begin
            wait_status(8'h08, "R7 drain ready");
            for (int i = 0; i < SB; i++) hread(0, v);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        hread(8, v);
        check(v == 8'h40, "R1 reset status", v, 8'h40);
        check(irq == 0 && proto_err == 0 && st_req == 0, "R1 reset outputs",
              {irq, proto_err, st_req}, 0);

        // R12 register readback
        hwrite(1, 8'hA1); hwrite(2, 8'h02); hwrite(3, 8'hB3);
        hwrite(4, 8'hC4); hwrite(5, 8'hD5); hwrite(6, 8'hE6);
        hread(1, v); check(v == 8'hA1, "R12 feature", v, 8'hA1);
        hread(2, v); check(v == 8'h02, "R12 count", v, 8'h02);
        hread(3, v); check(v == 8'hB3, "R12 sector number", v, 8'hB3);
        hread(4, v); check(v == 8'hC4, "R12 cylinder low", v, 8'hC4);
        hread(5, v); check(v == 8'hD5, "R12 cylinder high", v, 8'hD5);
        hread(6, v); check(v == 8'hE6, "R12 drive/head", v, 8'hE6);

        // R3 unsupported codes ignored
        hwrite(7, 8'hEC); hread(8, v); check(v == 8'h40, "R3 code EC ignored", v, 8'h40);
        hwrite(7, 8'h22); hread(8, v); check(v == 8'h40, "R3 code 22 ignored", v, 8'h40);
        check(proto_err == 0, "R3 no error", proto_err, 0);

        // write of two sectors, drive 1 (R3, R6, R10, R13)
        setup(8'd2, 8'h53, 8'h12, 8'h34, 8'h56);
        wlog_byte.delete(); req_lba.delete(); req_drv.delete();
        hwrite(7, 8'h31);
        for (int s = 0; s < 2; s++) begin
            wait_status(8'h08, "R3 write enters load");
            for (int i = 0; i < SB; i++) hwrite(0, pat(s, i) ^ 8'hA5);
        end
        wait_status(8'h40, "R7 write ends idle");
        check(irq == 1, "R8 irq after write", irq, 1);
        check(wlog_byte.size() == 2 * SB, "R13 stored byte count", wlog_byte.size(), 2 * SB);
        for (int k = 0; k < wlog_byte.size() && k < 2 * SB; k++)
            check(wlog_byte[k] == int'(pat(k / SB, k % SB) ^ 8'hA5), "R13 stored byte order",
                  wlog_byte[k], pat(k / SB, k % SB) ^ 8'hA5);
        check(req_lba.size() == 2 && req_lba[0] == 'h3123456 && req_lba[1] == 'h3123457,
              "R10 write block numbers", req_lba.size() > 1 ? req_lba[1] : -1, 'h3123457);
        check(req_drv.size() > 0 && req_drv[0] == 1, "R10 drive select",
              req_drv.size() > 0 ? req_drv[0] : -1, 1);

        // R9 alt status keeps irq, status clears it
        hread(8, v); check(irq == 1, "R9 alt read keeps irq", irq, 1);
        hread(7, v); check(irq == 0, "R9 status read clears irq", irq, 0);

        // R5 priming read of three sectors, drive 0
        setup(8'd3, 8'h40, 8'h00, 8'h00, 8'h10);
        req_lba.delete(); req_drv.delete();
        hwrite(7, 8'h20);
        hread(8, v); check(v == 8'h80, "R5 read starts busy", v, 8'h80);
        check(req_lba.size() == 1 && req_lba[0] == 'h10, "R5 priming fetch block",
              req_lba.size() > 0 ? req_lba[0] : -1, 'h10);
        drain_sectors(3);
        wait_status(8'h40, "R7 read ends idle");
        check(req_drv.size() > 0 && req_drv[0] == 0, "R10 drive 0 selected",
              req_drv.size() > 0 ? req_drv[0] : -1, 0);
        hread(7, v);

        // R8 masked interrupt
        hwrite(8, 8'h02);
        setup(8'd1, 8'h40, 8'h00, 8'h00, 8'h20);
        hwrite(7, 8'h21);
        drain_sectors(1);
        wait_status(8'h40, "R8 masked read idle");
        check(irq == 0, "R8 masked irq stays low", irq, 0);
        hwrite(8, 8'h00);

        // R8 control write clears a pending interrupt
        hwrite(7, 8'h20);
        drain_sectors(1);
        wait_status(8'h40, "R8 read idle");
        check(irq == 1, "R8 irq pending", irq, 1);
        hwrite(8, 8'h02);
        check(irq == 0, "R8 control write clears irq", irq, 0);
        hwrite(8, 8'h00);

        // R4 count zero means 256 sectors
        setup(8'd0, 8'h40, 8'h00, 8'h01, 8'h00);
        n_store_wr = 0;
        hwrite(7, 8'h30);
        for (int s = 0; s < 256; s++) begin
            wait_status(8'h08, "R4 sector load");
            for (int i = 0; i < SB; i++) hwrite(0, 8'(s + i));
        end
        wait_status(8'h40, "R4 idle after 256");
        check(n_store_wr == 256, "R4 store writes", n_store_wr, 256);
        hread(7, v);

        // R11 protocol errors
        check(proto_err == 0, "R11 clean before", proto_err, 0);
        hread(0, v);
        check(proto_err == 1, "R11 idle data read flags", proto_err, 1);
        setup(8'd1, 8'h40, 8'h00, 8'h00, 8'h05);
        hwrite(7, 8'h30);
        hwrite(7, 8'h20);
        hread(8, v); check(v == 8'h08, "R11 command while loading ignored", v, 8'h08);
        for (int i = 0; i < SB; i++) hwrite(0, 8'h5A);
        wait_status(8'h40, "R11 transfer completes");
        check(proto_err == 1, "R11 flag sticky", proto_err, 1);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule